// File: doc/BRIEF.md
# Split-Half Dual-Edge GPIO Controller

This block is a 32-pin general-purpose I/O controller whose every 32-bit state is reached through a 16-bit register port. Each state appears as a low half (pins 15:0) in one offset group and a high half (pins 31:16) at the same offset plus 0x500. It holds an output word, samples the input pins through one flop stage, and keeps two per-pin masks. One mask arms detection of a rising input; the other arms detection of a falling input. Detected edges land in a status word that is cleared by writing ones, and a single level interrupt is high while any status bit is set.

Some output bits also drive side signals. Output bits 18:16 form a 3-bit brightness code. Output bit 29 drives a serial data line and output bit 30 drives a serial clock line, so software can bit-bang a two-wire bus. A separate 3-bit brightness-enable register sits at offset 0x508.

The port is a plain select/write strobe pair. Writes take effect at the clock edge. Read data is combinational from the address while the select is high, and is zero while the select is low.

Top module: `gpio_split_ctrl`

## Requirements
- R1: The register map is: output at 0x00C, input at 0x010, falling-edge enable at 0x014, rising-edge enable at 0x018 and status at 0x020. Each of these offsets holds bits 15:0 of its word. The same offset plus 0x500 holds bits 31:16. Output, both enable masks and status reset to zero.
- R2: Writing one half of a word leaves the other half unchanged.
- R3: The input register returns the pins as sampled by one flop, so a pin change shows on a read after the next clock edge. After reset the input register reads all ones.
- R4: If a sampled pin goes from 0 to 1, its status bit is set on the following clock edge, but only when its rising-enable bit is 1.
- R5: If a sampled pin goes from 1 to 0, its status bit is set on the following clock edge, but only when its falling-enable bit is 1.
- R6: Writing a status half clears each bit written as 1 and keeps bits written as 0. If an edge sets a bit in the same cycle that a write clears it, the bit is left set.
- R7: irq_o is 1 exactly when at least one status bit is 1. It is 0 after reset.
- R8: bright_o equals output bits 18:16, ser_data_o equals output bit 29 and ser_clk_o equals output bit 30.
- R9: Offset 0x508 stores bits 2:0 of the write data and drives them on bright_en_o. A read returns them with bits 15:3 zero.
- R10: A write to the input offsets or to any unmapped offset changes no state. A read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 16 | Write data for one half |
| bus_rdata | output | 16 | Read data for the selected half |
| pins_i | input | 32 | Input pins |
| irq_o | output | 1 | Level interrupt, OR of status bits |
| bright_o | output | 3 | Brightness code from output bits 18:16 |
| bright_en_o | output | 3 | Brightness enable register |
| ser_data_o | output | 1 | Serial data line from output bit 29 |
| ser_clk_o | output | 1 | Serial clock line from output bit 30 |

## Verification
The assertions assume that pins_i and the register port are stable across each sampling edge. They also assume that a write names exactly one offset per cycle, so the half-preservation and clear properties see a single decoded target. The bench changes inputs only on the falling clock edge. It draws write addresses mostly from the mapped offsets, with a few unmapped ones. It flips a random subset of pins in about one cycle of four, so back-to-back edges and clears that coincide with set events both occur.

// File: rtl/gpio_split_pkg.sv
package gpio_split_pkg;
    localparam int HALF_W  = 16;
    localparam int PIN_W   = 2 * HALF_W;
    localparam int ADDR_W  = 12;
    localparam int BREN_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_OUT  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_IN   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_FEN  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_REN  = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_BREN = 12'h508;
    localparam logic [ADDR_W-1:0] HI_STEP  = 12'h500;

    typedef struct packed {
        logic [PIN_W-1:0]  outv;
        logic [PIN_W-1:0]  fen;
        logic [PIN_W-1:0]  ren;
        logic [PIN_W-1:0]  stat;
        logic [BREN_W-1:0] bren;
    } regs_t;

    function automatic logic [ADDR_W-1:0] half_ofs(input int h);
        return (h == 0) ? '0 : HI_STEP;
    endfunction
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] samp_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] samp;
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.samp = pins_i;
        st_d.prev = st_q.samp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign samp_o = st_q.samp;
    assign rise_o = st_q.samp & ~st_q.prev;
    assign fall_o = ~st_q.samp & st_q.prev;

    // R3: sampled value trails the pins by one edge
    a_r3_sample_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (samp_o == $past(pins_i)));
endmodule

// File: rtl/gpio_reg_core.sv
module gpio_reg_core
    import gpio_split_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic [PIN_W-1:0]  samp,
    input  logic [PIN_W-1:0]  rise,
    input  logic [PIN_W-1:0]  fall,
    output logic [HALF_W-1:0] rdata,
    output logic [PIN_W-1:0]  outv_o,
    output logic [PIN_W-1:0]  stat_o,
    output logic [BREN_W-1:0] bren_o
);
    regs_t rg_d, rg_q;
    logic [PIN_W-1:0] clr_mask;
    logic [PIN_W-1:0] evt;

    always_comb begin
        rg_d     = rg_q;
        clr_mask = '0;
        evt      = (rise & rg_q.ren) | (fall & rg_q.fen);
        if (wr_en) begin
            for (int h = 0; h < 2; h++) begin
                if (addr == OFS_OUT + half_ofs(h))  rg_d.outv[h*HALF_W +: HALF_W] = wdata;
                if (addr == OFS_FEN + half_ofs(h))  rg_d.fen[h*HALF_W +: HALF_W]  = wdata;
                if (addr == OFS_REN + half_ofs(h))  rg_d.ren[h*HALF_W +: HALF_W]  = wdata;
                if (addr == OFS_STAT + half_ofs(h)) clr_mask[h*HALF_W +: HALF_W]  = wdata;
            end
            if (addr == OFS_BREN) rg_d.bren = wdata[BREN_W-1:0];
        end
        rg_d.stat = (rg_q.stat & ~clr_mask) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int h = 0; h < 2; h++) begin
                if (addr == OFS_OUT + half_ofs(h))  rdata = rg_q.outv[h*HALF_W +: HALF_W];
                if (addr == OFS_IN + half_ofs(h))   rdata = samp[h*HALF_W +: HALF_W];
                if (addr == OFS_FEN + half_ofs(h))  rdata = rg_q.fen[h*HALF_W +: HALF_W];
                if (addr == OFS_REN + half_ofs(h))  rdata = rg_q.ren[h*HALF_W +: HALF_W];
                if (addr == OFS_STAT + half_ofs(h)) rdata = rg_q.stat[h*HALF_W +: HALF_W];
            end
            if (addr == OFS_BREN) rdata[BREN_W-1:0] = rg_q.bren;
        end
    end

    assign outv_o = rg_q.outv;
    assign stat_o = rg_q.stat;
    assign bren_o = rg_q.bren;

    // R2: a low-half output write keeps the high half
    a_r2_low_write_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_OUT) |=> $stable(outv_o[PIN_W-1:HALF_W]));

    // R2: a high-half rising-enable write keeps the low half
    a_r2_high_write_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == (OFS_REN + HI_STEP)) |=> $stable(rg_q.ren[HALF_W-1:0]));

    // R4, R5: a newly set status bit needs an armed edge in the cycle before
    a_r4_new_status_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(evt)) == '0));

    // R6: low-half clear removes written ones that had no coincident event
    a_r6_clear_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STAT) |=>
            ((stat_o[HALF_W-1:0] & $past(wdata & ~evt[HALF_W-1:0])) == '0));
endmodule

// File: rtl/gpio_split_ctrl.sv
module gpio_split_ctrl
    import gpio_split_pkg::*;
#(
    parameter int BRIGHT_LSB = 16,
    parameter int SDA_BIT    = 29,
    parameter int SCL_BIT    = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pins_i,
    output logic              irq_o,
    output logic [BREN_W-1:0] bright_o,
    output logic [BREN_W-1:0] bright_en_o,
    output logic              ser_data_o,
    output logic              ser_clk_o
);
    logic [PIN_W-1:0] samp, rise, fall, outv, stat;
    logic             wr_en;

    assign wr_en = bus_sel & bus_wr;

    gpio_edge_detect #(.W(PIN_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .samp_o (samp),
        .rise_o (rise),
        .fall_o (fall)
    );

    gpio_reg_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (bus_sel),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .samp   (samp),
        .rise   (rise),
        .fall   (fall),
        .rdata  (bus_rdata),
        .outv_o (outv),
        .stat_o (stat),
        .bren_o (bright_en_o)
    );

    assign irq_o      = |stat;
    assign bright_o   = outv[BRIGHT_LSB +: BREN_W];
    assign ser_data_o = outv[SDA_BIT];
    assign ser_clk_o  = outv[SCL_BIT];

    // R7: interrupt can only rise after some sampled edge
    a_r7_irq_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(rise | fall) != '0));

    // R8: side lines move only after a high-half output write
    a_r8_sides_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_addr == (OFS_OUT + HI_STEP)) |=>
            $stable({bright_o, ser_data_o, ser_clk_o}));
endmodule

// File: tb/gpio_split_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_split_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pins_i = '1;
    logic        irq_o;
    logic [2:0]  bright_o, bright_en_o;
    logic        ser_data_o, ser_clk_o;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    // reference model
    logic [31:0] m_out = '0, m_fen = '0, m_ren = '0, m_stat = '0;
    logic [31:0] m_samp = '1, m_prev = '1;
    logic [2:0]  m_bren = '0;

    always #10 clk = ~clk;

    gpio_split_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_i(pins_i), .irq_o(irq_o), .bright_o(bright_o),
        .bright_en_o(bright_en_o), .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.4;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [11:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(tag, {16'h0, v}, {16'h0, exp});
    endtask

    // one clock with optional write; called and returns at negedge
    task automatic cyc(input logic w, input logic [11:0] a, input logic [15:0] d,
                       input logic [31:0] p);
        logic [31:0] evt, clr, n_out, n_fen, n_ren;
        logic [2:0]  n_bren;
        bus_sel = w; bus_wr = w; bus_addr = a; bus_wdata = d; pins_i = p;
        evt = (m_samp & ~m_prev & m_ren) | (~m_samp & m_prev & m_fen);
        clr = '0; n_out = m_out; n_fen = m_fen; n_ren = m_ren; n_bren = m_bren;
        if (w) begin
            case (a)
                12'h00C: n_out[15:0]  = d;
                12'h50C: n_out[31:16] = d;
                12'h014: n_fen[15:0]  = d;
                12'h514: n_fen[31:16] = d;
                12'h018: n_ren[15:0]  = d;
                12'h518: n_ren[31:16] = d;
                12'h020: clr[15:0]    = d;
                12'h520: clr[31:16]   = d;
                12'h508: n_bren       = d[2:0];
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        m_stat = (m_stat & ~clr) | evt;
        m_prev = m_samp; m_samp = p;
        m_out = n_out; m_fen = n_fen; m_ren = n_ren; m_bren = n_bren;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic check_all();
        chk_rd("R1 out lo",  12'h00C, m_out[15:0]);
        chk_rd("R1 out hi",  12'h50C, m_out[31:16]);
        chk_rd("R3 in lo",   12'h010, m_samp[15:0]);
        chk_rd("R3 in hi",   12'h510, m_samp[31:16]);
        chk_rd("R1 fen lo",  12'h014, m_fen[15:0]);
        chk_rd("R1 fen hi",  12'h514, m_fen[31:16]);
        chk_rd("R1 ren lo",  12'h018, m_ren[15:0]);
        chk_rd("R1 ren hi",  12'h518, m_ren[31:16]);
        chk_rd("R6 stat lo", 12'h020, m_stat[15:0]);
        chk_rd("R6 stat hi", 12'h520, m_stat[31:16]);
        chk_rd("R9 bren",    12'h508, {13'h0, m_bren});
        chk_rd("R10 unmapped", 12'h008, 16'h0);
        chk("R7 irq", {31'h0, irq_o}, {31'h0, |m_stat});
        chk("R8 bright", {29'h0, bright_o}, {29'h0, m_out[18:16]});
        chk("R8 serial", {30'h0, ser_data_o, ser_clk_o}, {30'h0, m_out[29], m_out[30]});
        chk("R9 bren out", {29'h0, bright_en_o}, {29'h0, m_bren});
    endtask

    localparam logic [11:0] ADDRS [14] = '{12'h00C, 12'h50C, 12'h014, 12'h514,
        12'h018, 12'h518, 12'h020, 12'h520, 12'h508, 12'h010, 12'h510,
        12'h004, 12'h50A, 12'h100};

    initial begin
        #4_000_000;
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] p;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R3, R1, R7: reset state
        check_all();
        chk_rd("R3 reset in lo ones", 12'h010, 16'hFFFF);
        chk("R7 reset irq", {31'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R8: half writes and side outputs
        cyc(1, 12'h50C, 16'h4007, '1);
        cyc(1, 12'h00C, 16'hA5A5, '1);
        chk_rd("R2 hi kept", 12'h50C, 16'h4007);
        chk("R8 bright 7", {29'h0, bright_o}, 32'd7);
        chk("R8 scl high sda low", {30'h0, ser_data_o, ser_clk_o}, 32'd1);
        cyc(1, 12'h50C, 16'h2002, '1);
        chk("R8 sda high", {30'h0, ser_data_o, ser_clk_o}, 32'd2);
        chk_rd("R2 lo kept", 12'h00C, 16'hA5A5);

        // R9: only three bits stored
        cyc(1, 12'h508, 16'hFFFD, '1);
        chk_rd("R9 bren 5", 12'h508, 16'h0005);

        // R5: falling edge without enable, then R4 with rising enable
        cyc(1, 12'h018, 16'h0008, '1);
        cyc(0, 12'h0, 16'h0, 32'hFFFF_FFF7);
        chk_rd("R3 in shows low pin", 12'h010, 16'hFFF7);
        cyc(0, 12'h0, 16'h0, 32'hFFFF_FFF7);
        chk_rd("R5 fall not armed", 12'h020, 16'h0000);
        cyc(0, 12'h0, 16'h0, '1);
        chk_rd("R4 not yet set", 12'h020, 16'h0000);
        cyc(0, 12'h0, 16'h0, '1);
        chk_rd("R4 rise sets bit3", 12'h020, 16'h0008);
        chk("R7 irq high", {31'h0, irq_o}, 32'd1);

        // R5: falling edge with enable on a high pin
        cyc(1, 12'h514, 16'h0100, '1);
        cyc(0, 12'h0, 16'h0, 32'hFEFF_FFFF);
        cyc(0, 12'h0, 16'h0, 32'hFEFF_FFFF);
        chk_rd("R5 fall sets bit24", 12'h520, 16'h0100);

        // R6: clear low half only
        cyc(1, 12'h020, 16'hFFFF, 32'hFEFF_FFFF);
        chk_rd("R6 lo cleared", 12'h020, 16'h0000);
        chk_rd("R6 hi kept", 12'h520, 16'h0100);
        cyc(1, 12'h520, 16'h0100, 32'hFEFF_FFFF);
        chk("R7 irq low after clear", {31'h0, irq_o}, 32'd0);

        // R10: write to input and unmapped offsets ignored
        cyc(1, 12'h010, 16'h0000, 32'hFEFF_FFFF);
        cyc(1, 12'h004, 16'hFFFF, 32'hFEFF_FFFF);
        chk_rd("R10 input write ignored", 12'h010, 16'hFFFF);
        check_all();

        // constrained random with model comparison
        for (int i = 0; i < 3000; i++) begin
            logic w;
            logic [11:0] a;
            p = m_samp;
            if ($urandom_range(0, 3) == 0) p = pins_i ^ $urandom;
            else p = pins_i;
            w = ($urandom_range(0, 2) != 0);
            a = ADDRS[$urandom_range(0, 13)];
            cyc(w, a, 16'($urandom), p);
            check_all();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule